// File: doc/BRIEF.md
# Compressed Opcode Page Stack Controller

This block tracks which alternative opcode page is in force for a 16-bit compressed instruction space. The page-select instruction pushes an entry holding a subpage number and an activation length onto a small nested stack. Ordinary retired instructions count down the lifetime of the top entry, and the entry drops off when its lifetime runs out. A taken branch, an explicit "unwind one" command or an "unwind all" command also reshapes the stack. When the stack is empty the core decodes the default instruction set.

The retire interface is a plain strobe with no back-pressure. Retirement cannot be stalled, so the block accepts one decoded command in every cycle where `ret_valid` is high and has no ready signal. The whole stack is visible and writable as one status word, so that a context switch can save it and later restore it in a single cycle. The outputs report the active subpage, the stack depth, a default-mode flag and a one-cycle overflow pulse.

Top module: `opage_stack_ctrl`

## Requirements
- R1: After reset the depth is 0, `default_mode` is 1, `page_out` is 0, `overflow` is 0 and `csr_rdata` is all zeros.
- R2: A retired select command (`ret_cmd`=1) with depth below 4 stores entry {`ret_page`,`ret_len`} in slot `depth`. The depth then grows by 1, `page_out` shows `ret_page` from the next cycle, and `default_mode` goes to 0.
- R3: A select command with depth 4 leaves the stack and the status word unchanged. `overflow` is 1 in the following cycle only.
- R4: A retired ordinary instruction (`ret_cmd` 0, 5, 6 or 7) with a top entry whose length is between 2 and 14 reduces that length by 1. Nothing else changes.
- R5: An ordinary instruction whose top entry has length 0 or 1 removes that entry. The removed slot reads zero.
- R6: A top entry with length 15 is permanent: ordinary instructions never change it.
- R7: The unwind-one command (`ret_cmd`=2) removes exactly the top entry and zeroes its slot. On an empty stack it does nothing.
- R8: The unwind-all command (`ret_cmd`=3) empties the stack and zeroes every slot. Page commands (1, 2, 3) never decrement a length.
- R9: A taken branch (`ret_cmd`=4) empties the stack, permanent entries included.
- R10: `csr_rdata` is {depth[30:28], slot3, slot2, slot1, slot0}. Slot i sits at bits [7i+6:7i] as {page[6:4], length[3:0]}, and slot 0 is the bottom of the stack.
- R11: `csr_wr` loads all slots and the depth from `csr_wdata` (same layout) in one cycle and takes priority over a retire in the same cycle. A depth field above 4 is loaded as 4.
- R12: In a cycle with neither `ret_valid` nor `csr_wr`, the stack does not change. An ordinary instruction on an empty stack also leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | One instruction retires this cycle |
| ret_cmd | input | 3 | Decoded command type of the retiring instruction |
| ret_page | input | 3 | Subpage number carried by a select command |
| ret_len | input | 4 | Activation length carried by a select command |
| csr_wr | input | 1 | Load the whole stack from `csr_wdata` |
| csr_wdata | input | 31 | Status word to restore |
| csr_rdata | output | 31 | Current status word |
| page_out | output | 3 | Subpage of the top entry, 0 when the stack is empty |
| depth_out | output | 3 | Number of live entries |
| default_mode | output | 1 | High when no page is active |
| overflow | output | 1 | Pulse after a select command was refused |

## Verification
The assertions check on every cycle how each command type changes the depth. Pushes, refused pushes, unwinds, branches and idle cycles are covered, along with the restore path and its priority over retirement. Two behaviours depend on the length held in the top entry, which the port-level properties cannot follow: the countdown value, and the exact cycle in which an entry expires. The bench shows these by sweeping every activation length through its full lifetime. It then runs a long pseudo-random mix of commands and restores against an arithmetic model, and this mix covers the slot-zeroing and the clamped depth.

// File: rtl/opage_pkg.sv
package opage_pkg;
  typedef enum logic [2:0] {
    CMD_PLAIN  = 3'd0,
    CMD_SELECT = 3'd1,
    CMD_POP    = 3'd2,
    CMD_RESET  = 3'd3,
    CMD_BRANCH = 3'd4
  } cmd_e;

  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_LOAD  = 3'd1,
    OP_CLEAR = 3'd2,
    OP_POP   = 3'd3,
    OP_PUSH  = 3'd4,
    OP_DEC   = 3'd5,
    OP_FULL  = 3'd6
  } op_e;
endpackage

// File: rtl/opage_op_sel.sv
module opage_op_sel
  import opage_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int LEN_W = 4,
  parameter int CNT_W = 3
) (
  input  logic             csr_wr,
  input  logic             ret_valid,
  input  logic [2:0]       ret_cmd,
  input  logic [CNT_W-1:0] depth,
  input  logic [LEN_W-1:0] top_len,
  output op_e              op
);
  localparam logic [LEN_W-1:0] PERM = {LEN_W{1'b1}};
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic empty;
  assign empty = (depth == '0);

  always_comb begin
    op = OP_HOLD;
    if (csr_wr) begin
      op = OP_LOAD;
    end else if (ret_valid) begin
      case (ret_cmd)
        CMD_BRANCH, CMD_RESET: op = OP_CLEAR;
        CMD_POP:               op = empty ? OP_HOLD : OP_POP;
        CMD_SELECT:            op = (depth == FULL) ? OP_FULL : OP_PUSH;
        default: begin
          if (!empty && top_len != PERM)
            op = (top_len <= LEN_W'(1)) ? OP_POP : OP_DEC;
        end
      endcase
    end
  end
endmodule

// File: rtl/opage_stack_regs.sv
module opage_stack_regs
  import opage_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int ENT_W = 7,
  parameter int LEN_W = 4,
  parameter int CNT_W = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  op_e                    op,
  input  logic [ENT_W-1:0]       push_ent,
  input  logic [CNT_W-1:0]       load_depth,
  input  logic [DEPTH*ENT_W-1:0] load_ents,
  output logic [CNT_W-1:0]       depth,
  output logic [DEPTH*ENT_W-1:0] ents
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [CNT_W-1:0] depth_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic [ENT_W-1:0] slot_q;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        slot_q <= '0;
      end else begin
        case (op)
          OP_LOAD:  slot_q <= load_ents[i*ENT_W +: ENT_W];
          OP_CLEAR: slot_q <= '0;
          OP_POP:   if (depth_q == CNT_W'(i + 1)) slot_q <= '0;
          OP_PUSH:  if (depth_q == CNT_W'(i)) slot_q <= push_ent;
          OP_DEC:   if (depth_q == CNT_W'(i + 1))
                      slot_q[LEN_W-1:0] <= slot_q[LEN_W-1:0] - LEN_W'(1);
          default:  ;
        endcase
      end
    end
    assign ents[i*ENT_W +: ENT_W] = slot_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      depth_q <= '0;
    end else begin
      case (op)
        OP_LOAD:  depth_q <= (load_depth > FULL) ? FULL : load_depth;
        OP_CLEAR: depth_q <= '0;
        OP_POP:   depth_q <= depth_q - CNT_W'(1);
        OP_PUSH:  depth_q <= depth_q + CNT_W'(1);
        default:  ;
      endcase
    end
  end

  assign depth = depth_q;
endmodule

// File: rtl/opage_stack_ctrl.sv
module opage_stack_ctrl
  import opage_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int PAGE_W = 3,
  parameter int LEN_W  = 4,
  localparam int ENT_W = PAGE_W + LEN_W,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int CSR_W = DEPTH * ENT_W + CNT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_valid,
  input  logic [2:0]        ret_cmd,
  input  logic [PAGE_W-1:0] ret_page,
  input  logic [LEN_W-1:0]  ret_len,
  input  logic              csr_wr,
  input  logic [CSR_W-1:0]  csr_wdata,
  output logic [CSR_W-1:0]  csr_rdata,
  output logic [PAGE_W-1:0] page_out,
  output logic [CNT_W-1:0]  depth_out,
  output logic              default_mode,
  output logic              overflow
);
  op_e                    op;
  logic [CNT_W-1:0]       depth;
  logic [DEPTH*ENT_W-1:0] ents;
  logic [ENT_W-1:0]       top_ent;
  logic                   ovf_q;

  always_comb begin
    top_ent = '0;
    for (int i = 0; i < DEPTH; i++)
      if (depth == CNT_W'(i + 1)) top_ent = ents[i*ENT_W +: ENT_W];
  end

  opage_op_sel #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_sel (
    .csr_wr    (csr_wr),
    .ret_valid (ret_valid),
    .ret_cmd   (ret_cmd),
    .depth     (depth),
    .top_len   (top_ent[LEN_W-1:0]),
    .op        (op)
  );

  opage_stack_regs #(.DEPTH(DEPTH), .ENT_W(ENT_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .op         (op),
    .push_ent   ({ret_page, ret_len}),
    .load_depth (csr_wdata[CSR_W-1 -: CNT_W]),
    .load_ents  (csr_wdata[DEPTH*ENT_W-1:0]),
    .depth      (depth),
    .ents       (ents)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= (op == OP_FULL);
  end

  assign csr_rdata    = {depth, ents};
  assign page_out     = top_ent[ENT_W-1:LEN_W];
  assign depth_out    = depth;
  assign default_mode = (depth == '0);
  assign overflow     = ovf_q;
endmodule

// File: rtl/opage_stack_chk.sv
module opage_stack_chk #(
  parameter int DEPTH  = 4,
  parameter int PAGE_W = 3,
  parameter int LEN_W  = 4,
  localparam int ENT_W = PAGE_W + LEN_W,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int CSR_W = DEPTH * ENT_W + CNT_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ret_valid,
  input logic [2:0]        ret_cmd,
  input logic [PAGE_W-1:0] ret_page,
  input logic              csr_wr,
  input logic [CSR_W-1:0]  csr_wdata,
  input logic [CSR_W-1:0]  csr_rdata,
  input logic [PAGE_W-1:0] page_out,
  input logic [CNT_W-1:0]  depth_out,
  input logic              default_mode,
  input logic              overflow
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic retire;
  assign retire = ret_valid && !csr_wr;

  assert_depth_bound_R11: assert property (@(posedge clk) disable iff (!rst_n)
    depth_out <= FULL);

  assert_push_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && ret_cmd == 3'd1 && depth_out < FULL) |=>
      (depth_out == $past(depth_out) + CNT_W'(1)) && (page_out == $past(ret_page)) && !default_mode);

  assert_full_push_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && ret_cmd == 3'd1 && depth_out == FULL) |=> overflow && $stable(csr_rdata));

  assert_unwind_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && ret_cmd == 3'd2 && depth_out != '0) |=> depth_out == $past(depth_out) - CNT_W'(1));

  assert_unwind_all_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && ret_cmd == 3'd3) |=> csr_rdata == '0);

  assert_branch_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && ret_cmd == 3'd4) |=> (depth_out == '0) && default_mode);

  assert_restore_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && csr_wdata[CSR_W-1 -: CNT_W] <= FULL) |=> csr_rdata == $past(csr_wdata));

  assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (!ret_valid && !csr_wr) |=> $stable(csr_rdata));
endmodule

bind opage_stack_ctrl opage_stack_chk #(.DEPTH(DEPTH), .PAGE_W(PAGE_W), .LEN_W(LEN_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ret_valid    (ret_valid),
  .ret_cmd      (ret_cmd),
  .ret_page     (ret_page),
  .csr_wr       (csr_wr),
  .csr_wdata    (csr_wdata),
  .csr_rdata    (csr_rdata),
  .page_out     (page_out),
  .depth_out    (depth_out),
  .default_mode (default_mode),
  .overflow     (overflow)
);

// File: tb/test_opage_stack_ctrl.sv
module test_opage_stack_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ret_valid = 1'b0;
  logic [2:0]  ret_cmd = 3'd0;
  logic [2:0]  ret_page = 3'd0;
  logic [3:0]  ret_len = 4'd0;
  logic        csr_wr = 1'b0;
  logic [30:0] csr_wdata = '0;
  logic [30:0] csr_rdata;
  logic [2:0]  page_out;
  logic [2:0]  depth_out;
  logic        default_mode;
  logic        overflow;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [6:0] m_ent [4];
  int         m_depth;
  logic       m_ovf;
  logic [31:0] lfsr = 32'h1234_5678;

  always #4 clk = ~clk;

  opage_stack_ctrl i_opage_stack_ctrl (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_cmd(ret_cmd),
    .ret_page(ret_page), .ret_len(ret_len), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .page_out(page_out), .depth_out(depth_out),
    .default_mode(default_mode), .overflow(overflow)
  );

  function automatic logic [30:0] exp_csr();
    return {3'(m_depth), m_ent[3], m_ent[2], m_ent[1], m_ent[0]};
  endfunction

  task automatic check_all(input string tag);
    logic [38:0] got, exp;
    logic [2:0] ep;
    ep = (m_depth == 0) ? 3'd0 : m_ent[m_depth-1][6:4];
    got = {overflow, default_mode, page_out, depth_out, csr_rdata};
    exp = {m_ovf, (m_depth == 0), ep, 3'(m_depth), exp_csr()};
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got=%h expected=%h", tag, got, exp);
    end
  endtask

  function automatic int next_rand();
    lfsr = lfsr ^ (lfsr << 13);
    lfsr = lfsr ^ (lfsr >> 17);
    lfsr = lfsr ^ (lfsr << 5);
    return int'(lfsr[30:0]);
  endfunction

  task automatic step(input bit wr, input logic [30:0] wd, input bit v,
                      input logic [2:0] cmd, input logic [2:0] pg, input logic [3:0] ln);
    string tag;
    logic [3:0] tl;
    tl = (m_depth == 0) ? 4'd0 : m_ent[m_depth-1][3:0];
    if (wr) tag = "R11";
    else if (!v) tag = "R12";
    else if (cmd == 3'd4) tag = "R9";
    else if (cmd == 3'd3) tag = "R8";
    else if (cmd == 3'd2) tag = "R7";
    else if (cmd == 3'd1) tag = (m_depth == 4) ? "R3" : "R2";
    else if (m_depth == 0) tag = "R12";
    else if (tl == 4'd15) tag = "R6";
    else if (tl <= 4'd1) tag = "R5";
    else tag = "R4";
    csr_wr = wr; csr_wdata = wd; ret_valid = v; ret_cmd = cmd; ret_page = pg; ret_len = ln;
    m_ovf = 1'b0;
    if (wr) begin
      m_depth = (wd[30:28] > 3'd4) ? 4 : int'(wd[30:28]);
      for (int i = 0; i < 4; i++) m_ent[i] = wd[i*7 +: 7];
    end else if (v) begin
      if (cmd == 3'd4 || cmd == 3'd3) begin
        m_depth = 0;
        for (int i = 0; i < 4; i++) m_ent[i] = '0;
      end else if (cmd == 3'd2) begin
        if (m_depth > 0) begin m_depth--; m_ent[m_depth] = '0; end
      end else if (cmd == 3'd1) begin
        if (m_depth == 4) m_ovf = 1'b1;
        else begin m_ent[m_depth] = {pg, ln}; m_depth++; end
      end else if (m_depth > 0 && tl != 4'd15) begin
        if (tl <= 4'd1) begin m_depth--; m_ent[m_depth] = '0; end
        else m_ent[m_depth-1] = m_ent[m_depth-1] - 7'd1;
      end
    end
    @(posedge clk);
    @(negedge clk);
    csr_wr = 1'b0; ret_valid = 1'b0;
    check_all(tag);
  endtask

  task automatic sel(input int pg, input int ln);
    step(0, '0, 1, 3'd1, 3'(pg), 4'(ln));
  endtask

  task automatic plain();
    step(0, '0, 1, 3'd0, 3'd0, 4'd0);
  endtask

  initial begin
    m_depth = 0; m_ovf = 0;
    for (int i = 0; i < 4; i++) m_ent[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1");

    // R4 R5 R6: every activation length over its whole lifetime
    for (int ln = 0; ln < 16; ln++) begin
      sel(ln % 8, ln);
      for (int k = 0; k < 17; k++) plain();
      step(0, '0, 1, 3'd3, 3'd0, 4'd0);
    end

    // R2 R3 R7: fill, refuse, unwind past empty; R8 page cmds do not count down
    for (int d = 0; d < 4; d++) sel(d + 1, 5 + d);
    sel(7, 9);
    step(0, '0, 0, 3'd0, 3'd0, 4'd0);
    for (int k = 0; k < 5; k++) step(0, '0, 1, 3'd2, 3'd0, 4'd0);

    // R9: branch clears permanent entries
    sel(2, 15); sel(3, 15); plain();
    step(0, '0, 1, 3'd4, 3'd0, 4'd0);

    // R10 R11: restore, clamp, priority over branch
    step(1, {3'd2, 7'h11, 7'h22, 7'h3F, 7'h45}, 0, 3'd0, 3'd0, 4'd0);
    plain(); plain();
    step(1, {3'd7, 7'h7F, 7'h13, 7'h24, 7'h35}, 0, 3'd0, 3'd0, 4'd0);
    step(1, {3'd3, 7'h00, 7'h5F, 7'h62, 7'h71}, 1, 3'd4, 3'd0, 4'd0);
    step(0, '0, 1, 3'd3, 3'd0, 4'd0);

    // mixed stream against the model
    for (int n = 0; n < 3000; n++) begin
      int r, c;
      r = next_rand();
      c = r % 16;
      if (c == 15) begin
        logic [30:0] w;
        w = 31'(next_rand());
        step(1, w, (r >> 8) % 2 == 1, 3'((r >> 4) % 8), 3'(r >> 12), 4'(r >> 16));
      end else if (c < 6) step(0, '0, 1, 3'd0, 3'd0, 4'd0);
      else if (c < 10) step(0, '0, 1, 3'd1, 3'(r >> 5), 4'(r >> 9));
      else if (c < 12) step(0, '0, 1, 3'd2, 3'd0, 4'd0);
      else if (c == 12) step(0, '0, 1, 3'((r >> 5) % 2 == 1 ? 4 : 3), 3'd0, 4'd0);
      else if (c == 13) step(0, '0, 1, 3'(5 + (r >> 5) % 3), 3'd0, 4'd0);
      else step(0, '0, 0, 3'(r >> 5), 3'(r >> 8), 4'(r >> 11));
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule